// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Snooping

This block is a small pool of reservation stations serving a single class of functional unit in an out-of-order core. Each issued operation takes a free station. The block looks up a table that records which station will produce each register, and the operation's source operands are renamed against that table. An operand whose register has no pending writer takes the value supplied from the register file. Otherwise it stores the producer's tag and waits.

Every cycle the block watches a shared result bus, which carries a tag and a 64-bit value. Each waiting operand whose tag matches copies the value. The matching register-table entries are cleared, and the station that owns that tag is released. Among stations whose operands are both present and that have not yet been sent, one is picked each cycle and presented to the functional unit. The unit later puts its result on the bus under the station's tag.

Top module: `rs_bank`

## Requirements
- R1: After reset, `iss_ready` is 1, `iss_tag` is 1 and `disp_valid` is 0.
- R2: An accepted issue (`iss_valid` and `iss_ready`) takes the lowest-numbered free station. Station i (0-based) always carries tag i+1, which `iss_tag` shows before the edge.
- R3: When all stations are busy, `iss_ready` is 0 and an asserted `iss_valid` has no effect: no station is written and the register table is unchanged.
- R4: A source whose register has no pending writer captures the supplied value at issue. A station with both sources present appears on the dispatch port in the cycle after issue, with its opcode, both values, its address field and its own tag.
- R5: A source whose register has a pending writer holds that writer's tag, where tag 0 means "value present". When the bus later carries that tag, every waiting source with that tag copies the bus data.
- R6: If the bus carries the tag a source would wait on in the same cycle as the issue, the source takes the bus data directly and does not wait.
- R7: A station is dispatched only when both of its sources are present, and it is dispatched exactly once. A younger ready station may be dispatched ahead of an older one that is still waiting.
- R8: When several stations are ready in the same cycle, the lowest-numbered one is dispatched, one per cycle.
- R9: A bus transfer carrying a station's tag frees that station on the next edge.
- R10: At issue, the destination register's table entry is set to the new station's tag. A bus transfer clears only the table entries that still hold its tag, so a newer writer is not lost.
- R11: An operation's sources are looked up before its own destination entry is written, so an operation that reads and writes the same register does not wait on itself.
- R12: A synchronous reset, asserted at any time, frees every station and empties the register table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Opcode of the issued operation |
| iss_dst_en | input | 1 | Operation writes a register |
| iss_dst_reg | input | 4 | Destination register index |
| iss_src_j_reg | input | 4 | First source register index |
| iss_src_k_reg | input | 4 | Second source register index |
| iss_src_j_val | input | 64 | Register-file value of the first source |
| iss_src_k_val | input | 64 | Register-file value of the second source |
| iss_addr | input | 16 | Address or immediate field |
| iss_ready | output | 1 | A station is free |
| iss_tag | output | 4 | Tag the next accepted issue receives |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 4 | Producer tag on the result bus |
| cdb_data | input | 64 | Result value on the result bus |
| disp_valid | output | 1 | A station is being dispatched this cycle |
| disp_tag | output | 4 | Tag of the dispatched station |
| disp_op | output | 4 | Opcode of the dispatched station |
| disp_vj | output | 64 | First operand value |
| disp_vk | output | 64 | Second operand value |
| disp_addr | output | 16 | Address field of the dispatched station |

## Verification
The hardest situations to reach are timing coincidences. One is an issue that reads a register whose producer is on the result bus in that very cycle. Another is two stations that wake on the same bus transfer and then compete for dispatch. A third is a register that is overwritten by a second writer before the first writer's result returns. The bench reaches each one with a directed sequence. It issues a producer, lets it dispatch, then issues the consumer in exactly the cycle it drives the producer's tag on the bus. Likewise, two consumers are parked on one producer before its tag is broadcast. Ignored issues and table state are observed only through later dispatches.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_DATA_W = 64;
    localparam int RS_TAG_W  = 4;
    localparam int RS_OP_W   = 4;
    localparam int RS_ADDR_W = 16;

    typedef logic [RS_DATA_W-1:0] rs_data_t;
    typedef logic [RS_TAG_W-1:0]  rs_tag_t;
    typedef logic [RS_OP_W-1:0]   rs_op_t;
    typedef logic [RS_ADDR_W-1:0] rs_addr_t;

    // Tag value meaning "operand already present / no pending writer"
    localparam rs_tag_t TAG_NONE = '0;

    typedef struct packed {
        rs_op_t   op;
        rs_data_t vj;
        rs_data_t vk;
        rs_tag_t  qj;
        rs_tag_t  qk;
        rs_addr_t addr;
    } rs_slot_t;

    typedef struct packed {
        logic     valid;
        rs_tag_t  tag;
        rs_data_t data;
    } rs_bcast_t;

    typedef struct packed {
        rs_data_t v;
        rs_tag_t  q;
    } rs_opnd_t;

    // True when a pending tag is satisfied by the current broadcast
    function automatic logic tag_hit(rs_bcast_t b, rs_tag_t q);
        return b.valid && (q != TAG_NONE) && (q == b.tag);
    endfunction

    // Rename one source: register value, producer tag, or same-cycle bus value
    function automatic rs_opnd_t resolve_src(rs_tag_t pend, rs_data_t rf_val, rs_bcast_t b);
        rs_opnd_t r;
        if (pend == TAG_NONE) begin
            r.v = rf_val;
            r.q = TAG_NONE;
        end else if (tag_hit(b, pend)) begin
            r.v = b.data;
            r.q = TAG_NONE;
        end else begin
            r.v = '0;
            r.q = pend;
        end
        return r;
    endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N     = 5,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Lowest index wins
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat import rs_pkg::*; #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] rd_j,
    input  logic [REG_W-1:0] rd_k,
    output rs_tag_t          tag_j,
    output rs_tag_t          tag_k,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  rs_tag_t          wr_tag,
    input  logic             bc_valid,
    input  rs_tag_t          bc_tag
);
    rs_tag_t stat_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) stat_q[i] <= TAG_NONE;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_en && (wr_idx == REG_W'(i)))
                    stat_q[i] <= wr_tag;
                else if (bc_valid && (stat_q[i] != TAG_NONE) && (stat_q[i] == bc_tag))
                    stat_q[i] <= TAG_NONE;
            end
        end
    end

    // Reads return the state before this cycle's update
    assign tag_j = stat_q[rd_j];
    assign tag_k = stat_q[rd_k];
endmodule

// File: rtl/rs_entry.sv
module rs_entry import rs_pkg::*; #(
    parameter rs_tag_t MY_TAG = rs_tag_t'(1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  rs_slot_t  load_slot,
    input  logic      launch,
    input  rs_bcast_t bcast,
    output logic      busy,
    output logic      ready,
    output rs_slot_t  slot
);
    logic     busy_q;
    logic     launched_q;
    rs_slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            launched_q <= 1'b0;
        end else if (load) begin
            busy_q     <= 1'b1;
            launched_q <= 1'b0;
            slot_q     <= load_slot;
        end else if (busy_q) begin
            if (tag_hit(bcast, slot_q.qj)) begin
                slot_q.vj <= bcast.data;
                slot_q.qj <= TAG_NONE;
            end
            if (tag_hit(bcast, slot_q.qk)) begin
                slot_q.vk <= bcast.data;
                slot_q.qk <= TAG_NONE;
            end
            if (launch) launched_q <= 1'b1;
            if (bcast.valid && (bcast.tag == MY_TAG)) begin
                busy_q     <= 1'b0;
                launched_q <= 1'b0;
            end
        end
    end

    assign busy  = busy_q;
    assign ready = busy_q && !launched_q &&
                   (slot_q.qj == TAG_NONE) && (slot_q.qk == TAG_NONE);
    assign slot  = slot_q;
endmodule

// File: rtl/rs_bank.sv
module rs_bank import rs_pkg::*; #(
    parameter int NUM_RS   = 5,
    parameter int NUM_REGS = 16,
    parameter int TAG_BASE = 1,
    parameter int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic [RS_OP_W-1:0]   iss_op,
    input  logic                 iss_dst_en,
    input  logic [REG_W-1:0]     iss_dst_reg,
    input  logic [REG_W-1:0]     iss_src_j_reg,
    input  logic [REG_W-1:0]     iss_src_k_reg,
    input  logic [RS_DATA_W-1:0] iss_src_j_val,
    input  logic [RS_DATA_W-1:0] iss_src_k_val,
    input  logic [RS_ADDR_W-1:0] iss_addr,
    output logic                 iss_ready,
    output logic [RS_TAG_W-1:0]  iss_tag,
    input  logic                 cdb_valid,
    input  logic [RS_TAG_W-1:0]  cdb_tag,
    input  logic [RS_DATA_W-1:0] cdb_data,
    output logic                 disp_valid,
    output logic [RS_TAG_W-1:0]  disp_tag,
    output logic [RS_OP_W-1:0]   disp_op,
    output logic [RS_DATA_W-1:0] disp_vj,
    output logic [RS_DATA_W-1:0] disp_vk,
    output logic [RS_ADDR_W-1:0] disp_addr
);
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    rs_bcast_t        bcast;
    logic [NUM_RS-1:0] busy_vec;
    logic [NUM_RS-1:0] ready_vec;
    logic [NUM_RS-1:0] alloc_gnt;
    logic [NUM_RS-1:0] sel_gnt;
    logic [IDX_W-1:0]  alloc_idx;
    logic [IDX_W-1:0]  sel_idx;
    logic              alloc_any;
    logic              iss_fire;
    rs_tag_t           pend_j;
    rs_tag_t           pend_k;
    rs_opnd_t          src_j;
    rs_opnd_t          src_k;
    rs_slot_t          new_slot;
    rs_slot_t          slot_arr [NUM_RS];

    assign bcast = '{valid: cdb_valid, tag: cdb_tag, data: cdb_data};

    // Free-station allocation
    rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) alloc_pick_i (
        .req (~busy_vec),
        .gnt (alloc_gnt),
        .any (alloc_any),
        .idx (alloc_idx)
    );

    assign iss_ready = alloc_any;
    assign iss_tag   = rs_tag_t'(TAG_BASE + int'(alloc_idx));
    assign iss_fire  = iss_valid && alloc_any;

    // Register result-status table
    rs_regstat #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) regstat_i (
        .clk      (clk),
        .rst      (rst),
        .rd_j     (iss_src_j_reg),
        .rd_k     (iss_src_k_reg),
        .tag_j    (pend_j),
        .tag_k    (pend_k),
        .wr_en    (iss_fire && iss_dst_en),
        .wr_idx   (iss_dst_reg),
        .wr_tag   (iss_tag),
        .bc_valid (cdb_valid),
        .bc_tag   (cdb_tag)
    );

    // Operand renaming with same-cycle bus bypass
    always_comb begin
        src_j         = resolve_src(pend_j, iss_src_j_val, bcast);
        src_k         = resolve_src(pend_k, iss_src_k_val, bcast);
        new_slot.op   = iss_op;
        new_slot.vj   = src_j.v;
        new_slot.qj   = src_j.q;
        new_slot.vk   = src_k.v;
        new_slot.qk   = src_k.q;
        new_slot.addr = iss_addr;
    end

    // Station array
    for (genvar g = 0; g < NUM_RS; g++) begin : g_station
        rs_entry #(.MY_TAG(rs_tag_t'(TAG_BASE + g))) entry_i (
            .clk       (clk),
            .rst       (rst),
            .load      (iss_fire && alloc_gnt[g]),
            .load_slot (new_slot),
            .launch    (sel_gnt[g]),
            .bcast     (bcast),
            .busy      (busy_vec[g]),
            .ready     (ready_vec[g]),
            .slot      (slot_arr[g])
        );
    end

    // Dispatch select
    rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) sel_pick_i (
        .req (ready_vec),
        .gnt (sel_gnt),
        .any (disp_valid),
        .idx (sel_idx)
    );

    assign disp_tag = rs_tag_t'(TAG_BASE + int'(sel_idx));

    always_comb begin
        disp_op   = '0;
        disp_vj   = '0;
        disp_vk   = '0;
        disp_addr = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (sel_gnt[i]) begin
                disp_op   = slot_arr[i].op;
                disp_vj   = slot_arr[i].vj;
                disp_vk   = slot_arr[i].vk;
                disp_addr = slot_arr[i].addr;
            end
        end
    end
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
    parameter int NUM_RS   = 5,
    parameter int TAG_BASE = 1,
    parameter int TAG_W    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic              disp_valid,
    input logic [NUM_RS-1:0] busy_vec,
    input logic [NUM_RS-1:0] alloc_gnt,
    input logic [NUM_RS-1:0] sel_gnt
);
    assert_reset_frees_R12: assert property (@(posedge clk)
        rst |=> (busy_vec == '0));

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
        ((&busy_vec) && !cdb_valid) |=> (&busy_vec));

    assert_alloc_is_free_R2: assert property (@(posedge clk) disable iff (rst)
        iss_ready |-> ($onehot(alloc_gnt) && ((alloc_gnt & busy_vec) == '0)));

    assert_issue_marks_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> ((busy_vec & $past(alloc_gnt)) == $past(alloc_gnt)));

    assert_one_dispatch_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_gnt));

    assert_dispatch_busy_R7: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ((sel_gnt & ~busy_vec) == '0));

    for (genvar i = 0; i < NUM_RS; i++) begin : g_per
        assert_dispatch_once_R7: assert property (@(posedge clk) disable iff (rst)
            sel_gnt[i] |=> !sel_gnt[i]);

        assert_free_on_match_R9: assert property (@(posedge clk) disable iff (rst)
            (cdb_valid && (cdb_tag == TAG_W'(TAG_BASE + i)) &&
             !(iss_valid && iss_ready && alloc_gnt[i])) |=> !busy_vec[i]);
    end
endmodule

bind rs_bank rs_bank_chk #(.NUM_RS(NUM_RS), .TAG_BASE(TAG_BASE), .TAG_W(rs_pkg::RS_TAG_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .cdb_valid  (cdb_valid),
    .cdb_tag    (cdb_tag),
    .disp_valid (disp_valid),
    .busy_vec   (busy_vec),
    .alloc_gnt  (alloc_gnt),
    .sel_gnt    (sel_gnt)
);

// File: tb/rs_bank_tb_top.sv
`timescale 1ns/100ps
module rs_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0;
    logic        iss_dst_en = 1'b0;
    logic [3:0]  iss_dst_reg = '0;
    logic [3:0]  iss_src_j_reg = '0;
    logic [3:0]  iss_src_k_reg = '0;
    logic [63:0] iss_src_j_val = '0;
    logic [63:0] iss_src_k_val = '0;
    logic [15:0] iss_addr = '0;
    logic        iss_ready;
    logic [3:0]  iss_tag;
    logic        cdb_valid = 1'b0;
    logic [3:0]  cdb_tag = '0;
    logic [63:0] cdb_data = '0;
    logic        disp_valid;
    logic [3:0]  disp_tag;
    logic [3:0]  disp_op;
    logic [63:0] disp_vj;
    logic [63:0] disp_vk;
    logic [15:0] disp_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rs_bank dut_i (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst_en(iss_dst_en),
        .iss_dst_reg(iss_dst_reg), .iss_src_j_reg(iss_src_j_reg),
        .iss_src_k_reg(iss_src_k_reg), .iss_src_j_val(iss_src_j_val),
        .iss_src_k_val(iss_src_k_val), .iss_addr(iss_addr),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_vj(disp_vj), .disp_vk(disp_vk), .disp_addr(disp_addr)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [63:0] vj;
        logic [63:0] vk;
        logic [15:0] addr;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{op: 4'h1, vj: 64'h0000_0000_0000_0001, vk: 64'h0000_0000_0000_0002, addr: 16'h0010},
        '{op: 4'hF, vj: 64'hFFFF_FFFF_FFFF_FFFF, vk: 64'h0000_0000_0000_0000, addr: 16'hFFFF},
        '{op: 4'h0, vj: 64'h0000_0000_0000_0000, vk: 64'hFFFF_FFFF_FFFF_FFFF, addr: 16'h0000},
        '{op: 4'hA, vj: 64'hAAAA_AAAA_AAAA_AAAA, vk: 64'h5555_5555_5555_5555, addr: 16'hA5A5},
        '{op: 4'h5, vj: 64'h8000_0000_0000_0000, vk: 64'h0000_0000_0000_0001, addr: 16'h8001},
        '{op: 4'h7, vj: 64'h0123_4567_89AB_CDEF, vk: 64'hFEDC_BA98_7654_3210, addr: 16'h1234}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance to just after the next rising edge and idle the inputs
    task automatic next_cycle();
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
    endtask

    task automatic set_issue(input logic [3:0] op, input logic den, input logic [3:0] dst,
                             input logic [3:0] rj, input logic [3:0] rk,
                             input logic [63:0] vj, input logic [63:0] vk,
                             input logic [15:0] addr);
        iss_valid     = 1'b1;
        iss_op        = op;
        iss_dst_en    = den;
        iss_dst_reg   = dst;
        iss_src_j_reg = rj;
        iss_src_k_reg = rk;
        iss_src_j_val = vj;
        iss_src_k_val = vk;
        iss_addr      = addr;
    endtask

    task automatic set_bcast(input logic [3:0] t, input logic [63:0] d);
        cdb_valid = 1'b1;
        cdb_tag   = t;
        cdb_data  = d;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        next_cycle();
        rst = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1", "iss_ready", iss_ready, 1);
        chk("R1", "iss_tag", iss_tag, 1);
        chk("R1", "disp_valid", disp_valid, 0);

        // Vector walk: R4 capture and dispatch, R9 free
        for (int v = 0; v < NVEC; v++) begin
            set_issue(VECS[v].op, 1'b0, 4'd0, 4'd1, 4'd2, VECS[v].vj, VECS[v].vk, VECS[v].addr);
            #1;
            chk("R2", "iss_tag", iss_tag, 1);
            next_cycle();
            #1;
            chk("R4", "disp_valid", disp_valid, 1);
            chk("R4", "disp_tag", disp_tag, 1);
            chk("R4", "disp_op", disp_op, VECS[v].op);
            chk("R4", "disp_vj", disp_vj, VECS[v].vj);
            chk("R4", "disp_vk", disp_vk, VECS[v].vk);
            chk("R4", "disp_addr", disp_addr, VECS[v].addr);
            next_cycle();
            #1;
            chk("R7", "disp_valid once", disp_valid, 0);
            set_bcast(4'd1, 64'h0);
            next_cycle();
            #1;
            chk("R9", "iss_tag after free", iss_tag, 1);
        end

        // Dependency chain: R5, R7, R10
        do_reset();
        set_issue(4'h1, 1'b1, 4'd3, 4'd1, 4'd2, 64'd10, 64'd20, 16'h0);
        next_cycle();
        set_issue(4'h2, 1'b1, 4'd4, 4'd3, 4'd1, 64'd0, 64'd5, 16'h0);
        #1;
        chk("R4", "producer disp_tag", disp_tag, 1);
        chk("R2", "second iss_tag", iss_tag, 2);
        next_cycle();
        #1;
        chk("R7", "waiting not dispatched", disp_valid, 0);
        set_issue(4'h3, 1'b1, 4'd5, 4'd1, 4'd2, 64'd7, 64'd8, 16'h0);
        next_cycle();
        #1;
        chk("R7", "younger dispatched first", disp_tag, 3);
        chk("R7", "younger vj", disp_vj, 64'd7);
        next_cycle();
        set_bcast(4'd1, 64'h77);
        next_cycle();
        #1;
        chk("R5", "woken disp_valid", disp_valid, 1);
        chk("R5", "woken disp_tag", disp_tag, 2);
        chk("R5", "captured vj", disp_vj, 64'h77);
        chk("R5", "kept vk", disp_vk, 64'd5);
        next_cycle();
        set_issue(4'h4, 1'b0, 4'd0, 4'd3, 4'd3, 64'hAA, 64'hAA, 16'h0);
        #1;
        chk("R9", "freed tag reused", iss_tag, 1);
        next_cycle();
        #1;
        chk("R10", "cleared status disp_tag", disp_tag, 1);
        chk("R10", "cleared status vj", disp_vj, 64'hAA);

        // Two wake on one broadcast: R8
        do_reset();
        set_issue(4'h1, 1'b1, 4'd7, 4'd1, 4'd2, 64'd1, 64'd2, 16'h0);
        next_cycle();
        set_issue(4'h2, 1'b0, 4'd0, 4'd7, 4'd1, 64'd0, 64'd3, 16'h0);
        next_cycle();
        set_issue(4'h3, 1'b0, 4'd0, 4'd1, 4'd7, 64'd4, 64'd0, 16'h0);
        next_cycle();
        #1;
        chk("R7", "both waiting", disp_valid, 0);
        set_bcast(4'd1, 64'h99);
        next_cycle();
        #1;
        chk("R8", "lowest first tag", disp_tag, 2);
        chk("R8", "lowest first vj", disp_vj, 64'h99);
        next_cycle();
        #1;
        chk("R8", "second tag", disp_tag, 3);
        chk("R8", "second vk", disp_vk, 64'h99);
        chk("R8", "second vj", disp_vj, 64'd4);

        // Same-cycle bypass: R6
        do_reset();
        set_issue(4'h1, 1'b1, 4'd8, 4'd1, 4'd2, 64'd0, 64'd0, 16'h0);
        next_cycle();
        next_cycle();
        set_issue(4'h2, 1'b0, 4'd0, 4'd8, 4'd2, 64'd0, 64'd6, 16'h0);
        set_bcast(4'd1, 64'h1234);
        #1;
        chk("R6", "consumer tag", iss_tag, 2);
        next_cycle();
        #1;
        chk("R6", "bypass disp_valid", disp_valid, 1);
        chk("R6", "bypass disp_tag", disp_tag, 2);
        chk("R6", "bypass vj", disp_vj, 64'h1234);

        // Newer writer survives older broadcast: R10
        do_reset();
        set_issue(4'h1, 1'b1, 4'd9, 4'd1, 4'd2, 64'd0, 64'd0, 16'h0);
        next_cycle();
        set_issue(4'h2, 1'b1, 4'd9, 4'd1, 4'd2, 64'd0, 64'd0, 16'h0);
        next_cycle();
        next_cycle();
        set_bcast(4'd1, 64'h11);
        next_cycle();
        set_issue(4'h3, 1'b0, 4'd0, 4'd9, 4'd1, 64'hDEAD, 64'd2, 16'h0);
        next_cycle();
        #1;
        chk("R10", "reader waits on newer", disp_valid, 0);
        set_bcast(4'd2, 64'h22);
        next_cycle();
        #1;
        chk("R10", "reader disp_tag", disp_tag, 1);
        chk("R10", "reader vj", disp_vj, 64'h22);

        // Read-before-write of own destination: R11
        do_reset();
        set_issue(4'h5, 1'b1, 4'd10, 4'd10, 4'd10, 64'h55, 64'h66, 16'h0);
        next_cycle();
        #1;
        chk("R11", "self disp_valid", disp_valid, 1);
        chk("R11", "self vj", disp_vj, 64'h55);
        chk("R11", "self vk", disp_vk, 64'h66);

        // Full bank: R2 order, R3 ignored issue
        do_reset();
        for (int i = 0; i < 5; i++) begin
            set_issue(4'h6, 1'b1, 4'd12, 4'd1, 4'd2, 64'd0, 64'd0, 16'h0);
            #1;
            chk("R2", "fill order tag", iss_tag, i + 1);
            next_cycle();
        end
        #1;
        chk("R3", "full iss_ready", iss_ready, 0);
        set_issue(4'h7, 1'b1, 4'd11, 4'd1, 4'd2, 64'd0, 64'd0, 16'h0);
        next_cycle();
        #1;
        chk("R3", "ignored no dispatch", disp_valid, 0);
        set_bcast(4'd3, 64'h0);
        next_cycle();
        #1;
        chk("R3", "ready after free", iss_ready, 1);
        chk("R2", "lowest free tag", iss_tag, 3);
        set_issue(4'h8, 1'b0, 4'd0, 4'd11, 4'd1, 64'hBEEF, 64'd1, 16'h0);
        next_cycle();
        #1;
        chk("R3", "table untouched disp_tag", disp_tag, 3);
        chk("R3", "table untouched vj", disp_vj, 64'hBEEF);

        // Mid-run reset: R12
        do_reset();
        chk("R12", "iss_ready", iss_ready, 1);
        chk("R12", "iss_tag", iss_tag, 1);
        chk("R12", "disp_valid", disp_valid, 0);
        set_issue(4'h9, 1'b0, 4'd0, 4'd12, 4'd12, 64'hC0DE, 64'hC0DE, 16'h0);
        next_cycle();
        #1;
        chk("R12", "status cleared tag", disp_tag, 1);
        chk("R12", "status cleared vj", disp_vj, 64'hC0DE);

        finish_run();
    end
endmodule